// File: doc/BRIEF.md
# Completion interrupt coalescing unit

This block decides when a descriptor engine should tell software that work has finished. Each completed descriptor is presented with its control word. The block counts only those completions whose control word asks for an interrupt. A notification is sent when that count reaches a programmed threshold. It is also sent when an optional idle timeout expires while counted completions are still waiting.

The notification is a message-signalled interrupt: one posted write of a programmed 32-bit payload to a programmed 48-bit address. It leaves on a request/acknowledge port. Only one such write is in flight at a time. Completions that arrive while the write waits for its acknowledge are kept for the next message. Five small configuration registers hold the threshold, the timeout, the destination and the payload. Software writes them through a one-cycle write strobe with a register select.

Top module: `irq_coalescer`

## Requirements
- R1: After reset `msg_req` is 0, `msg_addr` and `msg_data` are 0, and the pending count is 0. The count threshold resets to 20, the timeout to 176, and the timeout path is disabled.
- R2: A completion counts only when `cmp_valid` is 1 and bit 27 of `cmp_ctrl` is 1. A completion with bit 27 clear leaves the pending count unchanged, whatever its other bits are.
- R3: Select 0 sets the count threshold in bits [14:0]. When the completion that makes the count equal to the threshold is sampled at edge E, `msg_req` is high after edge E+1. It is low after edge E.
- R4: A programmed count threshold of 0 behaves as 1: every counted completion fires a message.
- R5: Select 0 bit 18 enables the timeout path, and select 1 bits [12:0] hold the timeout T. If the first pending completion is counted at edge E and the count stays below the threshold, `msg_req` is high after edge E+1+T and low before it.
- R6: With the timeout path disabled, a pending count below the threshold never raises `msg_req`.
- R7: `msg_addr` is {select 3 bits [15:0], select 2 bits [31:0]}, and `msg_data` is select 4. Bits [31:16] written to select 3 are ignored.
- R8: At most one message is outstanding. `msg_addr` and `msg_data` hold steady until the edge that samples `msg_ack`, after which `msg_req` is low. Register writes made while the message is outstanding do not change it.
- R9: Sending a message clears the pending count. Completions counted while a message is outstanding go toward the next message. If they already meet the threshold, `msg_req` is high again after the edge that follows the acknowledging edge.
- R10: The timeout counter clears when a message is sent and holds at zero while a message is outstanding. After an acknowledge at edge A that leaves counts pending below the threshold, `msg_req` is high after edge A+1+T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 threshold/enable, 1 timeout, 2 address low, 3 address high, 4 payload |
| cfg_wdata | input | 32 | Register write data |
| cmp_valid | input | 1 | A descriptor completed this cycle |
| cmp_ctrl | input | 32 | Control word of the completed descriptor |
| msg_req | output | 1 | Message write requested |
| msg_addr | output | 48 | Message write address |
| msg_data | output | 32 | Message write payload |
| msg_ack | input | 1 | Message write accepted |

## Verification
A counted completion reaches the pending count at the edge that samples it. A threshold-triggered request appears one edge later. A timeout-triggered request appears T+1 edges after the first count, or T+1 edges after the acknowledge when counts are left pending. The bench drives every input just after a falling edge. It then checks `msg_req` at each falling edge in the window, so it confirms the request is low before its due cycle and high exactly in it. After an acknowledge it expects the request low at the next falling edge, and checks a re-fire one edge later.

// File: rtl/irq_coalescer.sv
module irq_coalescer #(
  parameter int THR_W   = 15,
  parameter int TMO_W   = 13,
  parameter int HI_W    = 16,
  parameter int LO_W    = 32,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int IOD_BIT = 27,
  parameter int TEN_BIT = 18,
  parameter int RST_THR = 20,
  parameter int RST_TMO = 176
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [2:0]             cfg_sel,
  input  logic [31:0]            cfg_wdata,
  input  logic                   cmp_valid,
  input  logic [31:0]            cmp_ctrl,
  output logic                   msg_req,
  output logic [HI_W+LO_W-1:0]   msg_addr,
  output logic [DATA_W-1:0]      msg_data,
  input  logic                   msg_ack
);
  localparam int AW = HI_W + LO_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [THR_W-1:0]  thr_q;
  logic              ten_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [LO_W-1:0]   lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [DATA_W-1:0] pay_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TMO_W-1:0]  tmr_q;
  logic              req_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] data_q;

  logic             qual, tmo_hit, fire, tmr_run;
  logic [CNT_W-1:0] thr_eff;

  assign qual    = cmp_valid & cmp_ctrl[IOD_BIT];
  assign thr_eff = (thr_q == '0) ? CNT_W'(1) : CNT_W'(thr_q);
  assign tmo_hit = ten_q && (tmr_q >= tmo_q);
  assign fire    = !req_q && (cnt_q != '0) && ((cnt_q >= thr_eff) || tmo_hit);
  assign tmr_run = ten_q && !req_q && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= THR_W'(RST_THR);
      ten_q <= 1'b0;
      tmo_q <= TMO_W'(RST_TMO);
      lo_q  <= '0;
      hi_q  <= '0;
      pay_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: begin
          thr_q <= cfg_wdata[THR_W-1:0];
          ten_q <= cfg_wdata[TEN_BIT];
        end
        3'd1: tmo_q <= cfg_wdata[TMO_W-1:0];
        3'd2: lo_q  <= cfg_wdata[LO_W-1:0];
        3'd3: hi_q  <= cfg_wdata[HI_W-1:0];
        3'd4: pay_q <= cfg_wdata[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (fire) begin
      cnt_q <= qual ? CNT_W'(1) : '0;
    end else if (qual && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fire || !tmr_run) begin
      tmr_q <= '0;
    end else if (tmr_q < tmo_q) begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (fire) begin
      req_q  <= 1'b1;
      addr_q <= {hi_q, lo_q};
      data_q <= pay_q;
    end else if (req_q && msg_ack) begin
      req_q  <= 1'b0;
    end
  end

  assign msg_req  = req_q;
  assign msg_addr = addr_q;
  assign msg_data = data_q;

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req && !msg_ack |=> msg_req && $stable(msg_addr) && $stable(msg_data));

  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req && msg_ack |=> !msg_req);

  a_r3_prompt: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_req && cnt_q != '0 && cnt_q >= thr_eff |=> msg_req);

  a_r2_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && !cmp_ctrl[IOD_BIT] && msg_req |=> cnt_q == $past(cnt_q));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_req) |-> cnt_q <= CNT_W'(1));

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> tmr_q == '0);
endmodule

// File: tb/irq_coalescer_tb.sv
module irq_coalescer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        cmp_valid;
  logic [31:0] cmp_ctrl;
  logic        msg_req;
  logic [47:0] msg_addr;
  logic [31:0] msg_data;
  logic        msg_ack;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  irq_coalescer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cmp_valid(cmp_valid), .cmp_ctrl(cmp_ctrl),
    .msg_req(msg_req), .msg_addr(msg_addr), .msg_data(msg_data),
    .msg_ack(msg_ack)
  );

  // {threshold[31:16], completions[15:8], expect_fire[0]}
  localparam logic [31:0] VEC [6] = '{
    {16'd3, 8'd2, 8'd0}, {16'd3, 8'd3, 8'd1}, {16'd0, 8'd1, 8'd1},
    {16'd1, 8'd1, 8'd1}, {16'd6, 8'd6, 8'd1}, {16'd6, 8'd5, 8'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    cmp_valid = 0; cmp_ctrl = 0; msg_ack = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cmpl(input logic [31:0] ctrl);
    @(negedge clk);
    cmp_valid = 1; cmp_ctrl = ctrl;
    @(negedge clk);
    cmp_valid = 0; cmp_ctrl = 0;
  endtask

  task automatic ack();
    @(negedge clk);
    msg_ack = 1;
    @(negedge clk);
    msg_ack = 0;
  endtask

  localparam logic [31:0] IOD = 32'h0800_0000;

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0;
    do_reset();
    @(negedge clk);
    chk(msg_req == 0 && msg_addr == 0 && msg_data == 0, "R1 reset outputs",
        {msg_req, msg_addr}, 0);

    // R1 default threshold 20: 19 completions do not fire, the 20th does
    for (int i = 0; i < 19; i++) cmpl(IOD);
    @(negedge clk);
    chk(msg_req == 0, "R1 default thr below", msg_req, 0);
    cmpl(IOD);
    chk(msg_req == 0, "R3 early", msg_req, 0);
    @(negedge clk);
    chk(msg_req == 1, "R1 default thr fire", msg_req, 1);

    // R1 default timeout 176 once enabled
    do_reset();
    wr(3'd0, 32'h0004_0000 | 32'd20);
    cmpl(IOD);
    repeat (176) @(negedge clk);
    chk(msg_req == 0, "R1 default tmo early", msg_req, 0);
    @(negedge clk);
    chk(msg_req == 1, "R1 default tmo fire", msg_req, 1);

    // R3/R4 table
    for (int v = 0; v < 6; v++) begin
      do_reset();
      wr(3'd0, {16'd0, VEC[v][31:16]});
      for (int k = 0; k < int'(VEC[v][15:8]); k++) cmpl(IOD);
      chk(msg_req == 0, "R3 not before due", msg_req, 0);
      @(negedge clk);
      chk(msg_req == VEC[v][0], (VEC[v][31:16] == 0) ? "R4 zero thr" : "R3 threshold",
          msg_req, VEC[v][0]);
    end

    // R2 non-qualifying completions ignored
    do_reset();
    wr(3'd0, 32'd1);
    cmpl(32'hF7FF_FFFF);
    cmpl(32'hF7FF_FFFF);
    repeat (3) @(negedge clk);
    chk(msg_req == 0, "R2 no iod bit", msg_req, 0);
    cmpl(IOD);
    @(negedge clk);
    chk(msg_req == 1, "R2 iod bit counts", msg_req, 1);

    // R5 timeout T=3 and T=0
    do_reset();
    wr(3'd1, 32'd3);
    wr(3'd0, 32'h0004_0000 | 32'd100);
    cmpl(IOD);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(msg_req == 0, "R5 tmo early", msg_req, 0);
    end
    @(negedge clk);
    chk(msg_req == 1, "R5 tmo fire", msg_req, 1);
    do_reset();
    wr(3'd1, 32'd0);
    wr(3'd0, 32'h0004_0000 | 32'd100);
    cmpl(IOD);
    @(negedge clk);
    chk(msg_req == 1, "R5 tmo zero", msg_req, 1);

    // R6 timer disabled
    do_reset();
    wr(3'd1, 32'd1);
    wr(3'd0, 32'd100);
    cmpl(IOD);
    repeat (20) @(negedge clk);
    chk(msg_req == 0, "R6 timer off", msg_req, 0);

    // R7/R8/R9 message contents, hold, re-fire
    do_reset();
    wr(3'd2, 32'hDEAD_BEEF);
    wr(3'd3, 32'hABCD_1234);
    wr(3'd4, 32'h5A5A_0001);
    wr(3'd0, 32'd2);
    cmpl(IOD);
    cmpl(IOD);
    @(negedge clk);
    chk(msg_req == 1, "R3 thr 2", msg_req, 1);
    chk(msg_addr == 48'h1234_DEAD_BEEF, "R7 address", msg_addr, 48'h1234_DEAD_BEEF);
    chk(msg_data == 32'h5A5A_0001, "R7 payload", msg_data, 32'h5A5A_0001);
    for (int i = 0; i < 3; i++) cmpl(IOD);
    wr(3'd2, 32'h0000_1111);
    wr(3'd4, 32'h0000_2222);
    chk(msg_req == 1 && msg_addr == 48'h1234_DEAD_BEEF && msg_data == 32'h5A5A_0001,
        "R8 held", {msg_req, msg_addr}, {1'b1, 48'h1234_DEAD_BEEF});
    ack();
    chk(msg_req == 0, "R8 drop after ack", msg_req, 0);
    @(negedge clk);
    chk(msg_req == 1, "R9 refire", msg_req, 1);
    chk(msg_addr == 48'h1234_0000_1111 && msg_data == 32'h2222, "R7 new message",
        msg_addr, 48'h1234_0000_1111);
    ack();
    repeat (10) @(negedge clk);
    chk(msg_req == 0, "R9 count cleared", msg_req, 0);

    // R10 timer restarts after ack
    do_reset();
    wr(3'd1, 32'd2);
    wr(3'd0, 32'h0004_0000 | 32'd10);
    cmpl(IOD);
    repeat (3) @(negedge clk);
    chk(msg_req == 1, "R5 tmo 2", msg_req, 1);
    cmpl(IOD);
    repeat (6) @(negedge clk);
    chk(msg_req == 1, "R8 waits ack", msg_req, 1);
    ack();
    chk(msg_req == 0, "R10 after ack", msg_req, 0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(msg_req == 0, "R10 tmo early", msg_req, 0);
    end
    @(negedge clk);
    chk(msg_req == 1, "R10 tmo refire", msg_req, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule